// File: doc/BRIEF.md
# Debug Halt Sequencer

This block decides when a processor core stops for debugging and when it starts again. It follows three states: running, debug and error. A break can come from a software break-now bit or from the breakpoint and trace logic. Breaks count only while the debug enable input is high. When a break is accepted in the running state, the block raises a halt request toward the pipeline. It then waits for the pipeline to report that it has drained, and enters debug at that point. The instruction that caused the break is never executed, and the core's PC and next-PC at the moment of entry are kept for the restart.

While in debug, tracing and the time tag counter are suspended. The timer and watchdog unit is also frozen if the freeze option is set. A core that has stopped in error mode can be taken straight into debug. Debug ends when the break-now bit falls or when debug enable drops. The block then issues a one-cycle resume strobe carrying the restart PC and next-PC. These are either the saved pair or a programmed address and that address plus four. Leaving debug after an error clears the error state.

Top module: `dbg_mode_ctrl`

## Requirements
- R1: After reset the state is running, and `halt_req`, `timer_frz`, `trace_susp` and `resume` are all low.
- R2: In the running state, a high `brk_now` or `brk_req` while `dbg_en` is high raises `halt_req` one cycle later and holds it. While `dbg_en` is low, both break sources are ignored and `halt_req` stays low.
- R3: While a halt is pending, a high `halt_ack` at a clock edge moves the state to debug at that edge.
- R4: If `halt_ack` never comes, the state still moves to debug at the (MAX_DRAIN+1)-th clock edge after `halt_req` rose (MAX_DRAIN = 4 by default). This covers the worst case of four instructions still in flight.
- R5: In debug, `halt_req` and `trace_susp` are high, and `timer_frz` equals `frz_cfg`. `timer_frz` is never high outside debug.
- R6: Debug ends at the edge where `dbg_en` is low, or where `brk_now` is low after having been high at the previous edge. In the first running cycle that follows, `resume` is high for exactly one cycle, and `halt_req`, `timer_frz` and `trace_susp` are low.
- R7: If `rst_addr_vld` is low when debug ends, `resume_pc` and `resume_npc` equal the `core_pc` and `core_npc` captured at debug entry. Later changes of `core_pc` have no effect on them.
- R8: If `rst_addr_vld` is high when debug ends, `resume_pc` equals `rst_addr` and `resume_npc` equals `rst_addr + 4`.
- R9: A high `err_mode` in the running state moves the state to error at the next edge. It cancels any pending halt, so `halt_req` goes low.
- R10: In the error state, an enabled break enters debug at the next edge without waiting for `halt_ack`. Leaving that debug returns to running, with the resume strobe, so error mode is cleared.
- R11: `dbg_state` reports running as 2'b00, debug as 2'b01 and error as 2'b10. It never shows 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_en | input | 1 | Debug enable pin |
| brk_now | input | 1 | Software break-now control bit |
| brk_req | input | 1 | Break request from breakpoint/trace logic |
| err_mode | input | 1 | Core has entered error mode |
| halt_ack | input | 1 | Pipeline has drained and stopped |
| frz_cfg | input | 1 | Freeze timers while in debug |
| core_pc | input | AW | Current PC from the core |
| core_npc | input | AW | Current next-PC from the core |
| rst_addr_vld | input | 1 | Use programmed restart address |
| rst_addr | input | AW | Programmed restart address |
| halt_req | output | 1 | Halt request to the pipeline |
| timer_frz | output | 1 | Timer/watchdog freeze |
| trace_susp | output | 1 | Suspend tracing and time tag counter |
| resume | output | 1 | One-cycle restart strobe |
| resume_pc | output | AW | Restart PC |
| resume_npc | output | AW | Restart next-PC |
| dbg_state | output | 2 | Current state encoding |

## Verification
The hardest case to reach is the forced entry into debug when the pipeline never acknowledges the halt. The bench holds `halt_ack` low, counts edges from the first cycle `halt_req` is seen, and checks that the state is still running after the fourth edge and in debug after the fifth. A second hard case is a pending halt overtaken by an error. The stimulus raises `err_mode` in the cycle right after the break is accepted, then brings the core out of error through debug with a programmed restart address.

// File: rtl/dbg_mode_pkg.sv
package dbg_mode_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'b00,
    ST_DEBUG = 2'b01,
    ST_ERROR = 2'b10
  } dbg_state_e;
endpackage

// File: rtl/dbg_entry_fsm.sv
module dbg_entry_fsm
  import dbg_mode_pkg::*;
#(
  parameter int MAX_DRAIN = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbg_en,
  input  logic       brk_now,
  input  logic       brk_req,
  input  logic       err_mode,
  input  logic       halt_ack,
  output dbg_state_e state_q,
  output logic       pend_q,
  output logic       enter_dbg,
  output logic       leave_dbg
);
  localparam int CW = $clog2(MAX_DRAIN + 1);

  dbg_state_e      state_d;
  logic            pend_d;
  logic [CW-1:0]   drain_q, drain_d;
  logic            bn_prev_q;
  logic            brk_any;
  logic            drain_done;

  assign brk_any    = dbg_en & (brk_now | brk_req);
  assign drain_done = (drain_q == CW'(MAX_DRAIN));

  always_comb begin
    state_d   = state_q;
    pend_d    = pend_q;
    drain_d   = drain_q;
    enter_dbg = 1'b0;
    leave_dbg = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (err_mode) begin
          state_d = ST_ERROR;
          pend_d  = 1'b0;
          drain_d = '0;
        end else if (pend_q) begin
          if (halt_ack || drain_done) begin
            state_d   = ST_DEBUG;
            pend_d    = 1'b0;
            drain_d   = '0;
            enter_dbg = 1'b1;
          end else begin
            drain_d = drain_q + CW'(1);
          end
        end else if (brk_any) begin
          pend_d  = 1'b1;
          drain_d = '0;
        end
      end
      ST_ERROR: begin
        if (brk_any) begin
          state_d   = ST_DEBUG;
          enter_dbg = 1'b1;
        end
      end
      ST_DEBUG: begin
        if (!dbg_en || (bn_prev_q && !brk_now)) begin
          state_d   = ST_RUN;
          leave_dbg = 1'b1;
        end
      end
      default: begin
        state_d = ST_RUN;
        pend_d  = 1'b0;
        drain_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RUN;
      pend_q    <= 1'b0;
      drain_q   <= '0;
      bn_prev_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      pend_q    <= pend_d;
      drain_q   <= drain_d;
      bn_prev_q <= brk_now;
    end
  end
endmodule

// File: rtl/dbg_resume_ctx.sv
module dbg_resume_ctx #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enter_dbg,
  input  logic          leave_dbg,
  input  logic [AW-1:0] core_pc,
  input  logic [AW-1:0] core_npc,
  input  logic          rst_addr_vld,
  input  logic [AW-1:0] rst_addr,
  output logic          resume,
  output logic [AW-1:0] resume_pc,
  output logic [AW-1:0] resume_npc
);
  localparam logic [AW-1:0] INSN_STEP = AW'(4);

  logic [AW-1:0] save_pc_q, save_npc_q;
  logic [AW-1:0] next_pc, next_npc;

  always_comb begin
    if (rst_addr_vld) begin
      next_pc  = rst_addr;
      next_npc = rst_addr + INSN_STEP;
    end else begin
      next_pc  = save_pc_q;
      next_npc = save_npc_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      save_pc_q  <= '0;
      save_npc_q <= '0;
    end else if (enter_dbg) begin
      save_pc_q  <= core_pc;
      save_npc_q <= core_npc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resume_pc  <= '0;
      resume_npc <= '0;
    end else if (leave_dbg) begin
      resume_pc  <= next_pc;
      resume_npc <= next_npc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) resume <= 1'b0;
    else        resume <= leave_dbg;
  end
endmodule

// File: rtl/dbg_mode_ctrl.sv
module dbg_mode_ctrl
  import dbg_mode_pkg::*;
#(
  parameter int AW        = 32,
  parameter int MAX_DRAIN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dbg_en,
  input  logic          brk_now,
  input  logic          brk_req,
  input  logic          err_mode,
  input  logic          halt_ack,
  input  logic          frz_cfg,
  input  logic [AW-1:0] core_pc,
  input  logic [AW-1:0] core_npc,
  input  logic          rst_addr_vld,
  input  logic [AW-1:0] rst_addr,
  output logic          halt_req,
  output logic          timer_frz,
  output logic          trace_susp,
  output logic          resume,
  output logic [AW-1:0] resume_pc,
  output logic [AW-1:0] resume_npc,
  output logic [1:0]    dbg_state
);
  dbg_state_e state_q;
  logic       pend_q, enter_dbg, leave_dbg, in_dbg;

  dbg_entry_fsm #(.MAX_DRAIN(MAX_DRAIN)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_en    (dbg_en),
    .brk_now   (brk_now),
    .brk_req   (brk_req),
    .err_mode  (err_mode),
    .halt_ack  (halt_ack),
    .state_q   (state_q),
    .pend_q    (pend_q),
    .enter_dbg (enter_dbg),
    .leave_dbg (leave_dbg)
  );

  dbg_resume_ctx #(.AW(AW)) u_ctx (
    .clk          (clk),
    .rst_n        (rst_n),
    .enter_dbg    (enter_dbg),
    .leave_dbg    (leave_dbg),
    .core_pc      (core_pc),
    .core_npc     (core_npc),
    .rst_addr_vld (rst_addr_vld),
    .rst_addr     (rst_addr),
    .resume       (resume),
    .resume_pc    (resume_pc),
    .resume_npc   (resume_npc)
  );

  assign in_dbg     = (state_q == ST_DEBUG);
  assign halt_req   = pend_q | in_dbg;
  assign trace_susp = in_dbg;
  assign timer_frz  = in_dbg & frz_cfg;
  assign dbg_state  = state_q;
endmodule

// File: rtl/dbg_mode_ctrl_chk.sv
module dbg_mode_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          err_mode,
  input logic          frz_cfg,
  input logic          rst_addr_vld,
  input logic [AW-1:0] rst_addr,
  input logic          halt_req,
  input logic          timer_frz,
  input logic          trace_susp,
  input logic          resume,
  input logic [AW-1:0] resume_pc,
  input logic [AW-1:0] resume_npc,
  input logic [1:0]    dbg_state
);
  AST_DEBUG_HOLDS_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_state == 2'b01) |-> (halt_req && trace_susp && (timer_frz == frz_cfg))); // R5

  AST_FRZ_ONLY_IN_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    timer_frz |-> (dbg_state == 2'b01)); // R5

  AST_RESUME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    resume |=> !resume); // R6

  AST_RESUME_AFTER_DEBUG: assert property (@(posedge clk) disable iff (!rst_n)
    resume |-> ((dbg_state == 2'b00) && ($past(dbg_state) == 2'b01) && !halt_req)); // R6

  AST_RESTART_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (resume && $past(rst_addr_vld)) |->
      ((resume_pc == $past(rst_addr)) && (resume_npc == resume_pc + AW'(4)))); // R8

  AST_ERROR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    ((dbg_state == 2'b00) && err_mode) |=> ((dbg_state == 2'b10) && !halt_req)); // R9

  AST_LEGAL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_state != 2'b11); // R11
endmodule

bind dbg_mode_ctrl dbg_mode_ctrl_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .err_mode     (err_mode),
  .frz_cfg      (frz_cfg),
  .rst_addr_vld (rst_addr_vld),
  .rst_addr     (rst_addr),
  .halt_req     (halt_req),
  .timer_frz    (timer_frz),
  .trace_susp   (trace_susp),
  .resume       (resume),
  .resume_pc    (resume_pc),
  .resume_npc   (resume_npc),
  .dbg_state    (dbg_state)
);

// File: tb/dbg_mode_ctrl_test.sv
module dbg_mode_ctrl_test;
  localparam int AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          dbg_en, brk_now, brk_req, err_mode, halt_ack, frz_cfg;
  logic [AW-1:0] core_pc, core_npc, rst_addr;
  logic          rst_addr_vld;
  logic          halt_req, timer_frz, trace_susp, resume;
  logic [AW-1:0] resume_pc, resume_npc;
  logic [1:0]    dbg_state;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  dbg_mode_ctrl #(.AW(AW), .MAX_DRAIN(4)) uut (
    .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .brk_now(brk_now),
    .brk_req(brk_req), .err_mode(err_mode), .halt_ack(halt_ack),
    .frz_cfg(frz_cfg), .core_pc(core_pc), .core_npc(core_npc),
    .rst_addr_vld(rst_addr_vld), .rst_addr(rst_addr),
    .halt_req(halt_req), .timer_frz(timer_frz), .trace_susp(trace_susp),
    .resume(resume), .resume_pc(resume_pc), .resume_npc(resume_npc),
    .dbg_state(dbg_state)
  );

  // inputs {en,bn,br,err,ack,frz} | expected {state[1:0],halt,frz,susp,resume}
  localparam logic [11:0] VEC [0:15] = '{
    12'b100001_000000, // R1 idle run
    12'b001001_000000, // R2 break ignored without enable
    12'b101001_001000, // R2 break accepted, halt pending
    12'b100001_001000, // R2 halt held while draining
    12'b100011_011110, // R3 ack enters debug, R5 freeze on
    12'b100001_011110, // R5 debug held
    12'b000001_000001, // R6 enable low resumes
    12'b100001_000000, // R6 strobe gone
    12'b110001_001000, // R2 break-now accepted
    12'b110010_011010, // R3 entry, R5 no freeze when frz_cfg low
    12'b110000_011010, // R6 break-now still high, stay
    12'b100000_000001, // R6 break-now falls, resume
    12'b100100_100000, // R9 error entry
    12'b100000_100000, // R9 error held
    12'b101001_011110, // R10 error to debug without ack
    12'b000001_000001  // R10 error cleared through resume
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [5:0] v);
    {dbg_en, brk_now, brk_req, err_mode, halt_ack, frz_cfg} = v;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(6'b000000);
    core_pc = 32'h100; core_npc = 32'h104;
    rst_addr_vld = 1'b0; rst_addr = '0;
    repeat (3) tick();
    // R1 and R11 reset state
    check("R1 outputs", {halt_req, timer_frz, trace_susp, resume}, 4'b0000);
    check("R11 state", dbg_state, 2'b00);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < 16; i++) begin
      drive(VEC[i][11:6]);
      tick();
      check($sformatf("vector %0d state/halt/frz/susp/resume", i),
            {dbg_state, halt_req, timer_frz, trace_susp, resume}, VEC[i][5:0]);
    end

    // R4 forced entry with no acknowledge
    drive(6'b101001); core_pc = 32'h200; core_npc = 32'h204;
    tick();
    check("R4 halt raised", {halt_req, dbg_state}, 3'b100);
    drive(6'b100001);
    for (int k = 1; k <= 4; k++) begin
      tick();
      check($sformatf("R4 still draining edge %0d", k), {halt_req, dbg_state}, 3'b100);
    end
    tick();
    check("R4 forced into debug", dbg_state, 2'b01);
    core_pc = 32'h999; core_npc = 32'h99d;
    tick();
    // R7 restart from saved pair
    drive(6'b000001);
    tick();
    check("R7 resume strobe", resume, 1'b1);
    check("R7 saved pc", resume_pc, 32'h200);
    check("R7 saved npc", resume_npc, 32'h204);
    drive(6'b100001);
    tick();
    check("R6 strobe one cycle", resume, 1'b0);

    // R8 programmed restart address
    drive(6'b110001); tick();
    drive(6'b110011); tick();
    check("R8 in debug", dbg_state, 2'b01);
    rst_addr_vld = 1'b1; rst_addr = 32'h1000;
    drive(6'b100001); tick();
    check("R8 restart pc", resume_pc, 32'h1000);
    check("R8 restart npc", resume_npc, 32'h1004);
    rst_addr_vld = 1'b0;
    tick();

    // R9 error overtakes pending halt
    drive(6'b101001); tick();
    check("R9 pending", halt_req, 1'b1);
    drive(6'b100101); tick();
    check("R9 error cancels halt", {dbg_state, halt_req}, 3'b100);
    drive(6'b100001); tick();

    // R10 error to debug, restart from saved pc
    core_pc = 32'h300; core_npc = 32'h304;
    drive(6'b101001); tick();
    check("R10 debug from error", dbg_state, 2'b01);
    core_pc = 32'h0; core_npc = 32'h0;
    drive(6'b000001); tick();
    check("R10 back to run", {dbg_state, resume}, 3'b001);
    check("R10 restart pc", resume_pc, 32'h300);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule